// File: doc/BRIEF.md
# Clock Source Switch Sequencer

This block steers run-time changes of a chip's system clock source. A 3-bit frequency code picks either a slow internal clock (code 000, nominally 31.25 kHz) or one tap of a postscaler on a fast internal oscillator. The codes 001 to 111 map to 125 kHz, 250 kHz, 500 kHz, 1 MHz, 2 MHz, 4 MHz and 8 MHz, doubling at each step. Software may rewrite the code at any moment, whatever source is driving the clock. The new tap is enabled at once. A stability flag reports whether the fast oscillator's frequency has settled.

The flag only re-arms its settle delay when the fast oscillator is woken from the slow setting. A delay of `SETTLE_US` microsecond ticks, 100 by default, then runs before the flag sets again. Moves between fast taps leave the flag as it is. Execution is never held back by the flag. A separate mode request selects either internal operation or one of three external crystal modes. A crystal source is handed over only after an oscillator start-up count of `OST_EDGES` oscillator edges, 1024 by default. The block drives clock enables only. The clock mux cells and the analog oscillators sit outside it.

Top module: `clksrc_seq`

## Requirements
- R1: After reset the code is 000, `tap_en` is 8'b0000_0001, `fast_stable` is 0, `ext_sel` is 0 and, with `mode_req` at 00, `clk_ready` is 1.
- R2: While `ext_sel` is 0, `tap_en` is one-hot with bit n set for code n. A write through `sel_wr` changes it on the clock edge that samples the strobe. While `ext_sel` is 1, `tap_en` is all zero.
- R3: Writing a nonzero code while the code is 000 leaves `fast_stable` at 0. The flag sets on the edge that samples the `SETTLE_US`-th `us_tick` after the write, and not before.
- R4: Writing a nonzero code while the code is nonzero leaves `fast_stable` unchanged. A settle countdown already running continues without restarting.
- R5: Writing code 000 clears `fast_stable` and cancels any running countdown. No later tick sets the flag until the next wake from 000.
- R6: A `us_tick` in the same cycle as a wake write is not counted. Ticks while no countdown runs have no effect.
- R7: In internal mode (`mode_req` 00), `clk_ready` stays 1 whatever the state of `fast_stable`.
- R8: In a crystal mode (`mode_req` 01, 10 or 11), `clk_ready` and `ext_sel` are 0 until `OST_EDGES` pulses on `xosc_edge` have been counted. Both go to 1 on the edge that samples the last counted pulse.
- R9: Any change of `mode_req` restarts the start-up count and drops `clk_ready` to 0 if the new mode is a crystal mode. An `xosc_edge` pulse in the cycle of the change, or any pulse while in internal mode, is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_wr | input | 1 | Write strobe for the frequency code |
| sel_code | input | 3 | New frequency code (000 slow clock, 001..111 fast taps) |
| mode_req | input | 2 | Source mode: 00 internal, 01/10/11 crystal modes |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| xosc_edge | input | 1 | One-cycle pulse per rising edge of the external oscillator |
| tap_en | output | 8 | One-hot enable of the internal source or tap |
| ext_sel | output | 1 | External crystal source selected |
| fast_stable | output | 1 | Fast internal oscillator frequency settled |
| clk_ready | output | 1 | Selected source usable for execution |

## Verification
The bench builds the block with `SETTLE_US` = 5 and `OST_EDGES` = 16. These small values put both the settle countdown and the start-up count within a few cycles. The bench then sweeps all 64 pairs of old and new frequency codes, checking the tap enable and the flag for each pair. It also finds the exact tick and edge at which each flag rises in all three crystal modes. With these short counts, the mid-count cases become cheap to reach: a restart, a cancellation, a tap change during the countdown, and a pulse that coincides with a write or a mode change.

// File: rtl/clksrc_seq.sv
module clksrc_seq #(
  parameter int SETTLE_US = 100,
  parameter int OST_EDGES = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_wr,
  input  logic [2:0] sel_code,
  input  logic [1:0] mode_req,
  input  logic       us_tick,
  input  logic       xosc_edge,
  output logic [7:0] tap_en,
  output logic       ext_sel,
  output logic       fast_stable,
  output logic       clk_ready
);
  localparam int SW = $clog2(SETTLE_US + 1);
  localparam int OW = $clog2(OST_EDGES + 1);
  localparam logic [SW-1:0] SETTLE_INIT = SW'(SETTLE_US);
  localparam logic [OW-1:0] OST_LAST = OW'(OST_EDGES - 1);

  logic [2:0]    code_q;
  logic [SW-1:0] settle_q;
  logic          run_q;
  logic          stable_q;
  logic [1:0]    mode_q;
  logic [OW-1:0] ost_q;
  logic          ost_done_q;

  wire to_slow  = sel_wr && (sel_code == 3'd0);
  wire wake     = sel_wr && (code_q == 3'd0) && (sel_code != 3'd0);
  wire mode_chg = (mode_req != mode_q);
  wire xtal     = (mode_q != 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= 3'd0;
      settle_q <= '0;
      run_q    <= 1'b0;
      stable_q <= 1'b0;
    end else begin
      if (sel_wr) code_q <= sel_code;
      if (to_slow) begin
        run_q    <= 1'b0;
        stable_q <= 1'b0;
        settle_q <= '0;
      end else if (wake) begin
        run_q    <= 1'b1;
        stable_q <= 1'b0;
        settle_q <= SETTLE_INIT;
      end else if (run_q && us_tick) begin
        if (settle_q == SW'(1)) begin
          run_q    <= 1'b0;
          stable_q <= 1'b1;
        end
        settle_q <= settle_q - SW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= 2'd0;
      ost_q      <= '0;
      ost_done_q <= 1'b0;
    end else begin
      mode_q <= mode_req;
      if (mode_chg) begin
        ost_q      <= '0;
        ost_done_q <= 1'b0;
      end else if (xtal && xosc_edge && !ost_done_q) begin
        ost_q <= ost_q + OW'(1);
        if (ost_q == OST_LAST) ost_done_q <= 1'b1;
      end
    end
  end

  assign fast_stable = stable_q;
  assign ext_sel     = xtal && ost_done_q;
  assign clk_ready   = !xtal || ost_done_q;
  assign tap_en      = ext_sel ? 8'd0 : (8'd1 << code_q);

  a_r2_tap_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_en) == (ext_sel ? 0 : 1));
  a_r3_wake_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !fast_stable);
  a_r4_fast_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && code_q != 3'd0 && sel_code != 3'd0 && fast_stable) |=> fast_stable);
  a_r5_slow_clears: assert property (@(posedge clk) disable iff (!rst_n)
    to_slow |=> (!fast_stable && tap_en[0] == !ext_sel));
  a_r6_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fast_stable) |-> $past(us_tick));
  a_r8_rise_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(clk_ready) && xtal) |-> $past(xosc_edge));
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_chg && mode_req != 2'd0) |=> !clk_ready);
endmodule

// File: tb/tb_clksrc_seq.sv
module tb_clksrc_seq;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 5;
  localparam int OST = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_wr = 1'b0;
  logic [2:0] sel_code = 3'd0;
  logic [1:0] mode_req = 2'd0;
  logic us_tick = 1'b0;
  logic xosc_edge = 1'b0;
  logic [7:0] tap_en;
  logic ext_sel, fast_stable, clk_ready;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clksrc_seq #(.SETTLE_US(SETTLE), .OST_EDGES(OST)) dut (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_code(sel_code),
    .mode_req(mode_req), .us_tick(us_tick), .xosc_edge(xosc_edge),
    .tap_en(tap_en), .ext_sel(ext_sel), .fast_stable(fast_stable),
    .clk_ready(clk_ready));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sel_wr = 0; us_tick = 0; xosc_edge = 0; mode_req = 0;
    step(); rst_n = 1'b1; step();
  endtask

  task automatic write_sel(input logic [2:0] c, input logic tick);
    sel_wr = 1'b1; sel_code = c; us_tick = tick;
    step();
    sel_wr = 1'b0; us_tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin us_tick = 1'b1; step(); us_tick = 1'b0; end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin xosc_edge = 1'b1; step(); xosc_edge = 1'b0; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 tap_en", tap_en, 8'h01);
    check("R1 fast_stable", fast_stable, 0);
    check("R1 ext_sel", ext_sel, 0);
    check("R1 clk_ready", clk_ready, 1);

    // R2/R4/R5 sweep over every old/new code pair, old fast source already settled
    for (int f = 0; f < 8; f++) begin
      for (int t = 0; t < 8; t++) begin
        do_reset();
        if (f != 0) begin write_sel(3'(f), 1'b0); ticks(SETTLE); end
        write_sel(3'(t), 1'b0);
        check("R2 tap after write", tap_en, 32'(8'd1 << t));
        check("R4/R5 stable after write", fast_stable, (f != 0 && t != 0) ? 1 : 0);
      end
    end

    // R3 settle timing for every fast tap, R7 ready while unsettled
    for (int t = 1; t < 8; t++) begin
      do_reset();
      write_sel(3'(t), 1'b0);
      check("R7 ready while unsettled", clk_ready, 1);
      ticks(SETTLE - 1);
      check("R3 not yet stable", fast_stable, 0);
      ticks(1);
      check("R3 stable after settle", fast_stable, 1);
    end

    // R6 tick in write cycle ignored; idle cycles do not count
    do_reset();
    write_sel(3'd3, 1'b1);
    step(); step();
    ticks(SETTLE - 1);
    check("R6 write-cycle tick ignored", fast_stable, 0);
    ticks(1);
    check("R6 stable on last tick", fast_stable, 1);

    // R6 ticks with no countdown do nothing
    do_reset();
    ticks(SETTLE + 2);
    check("R6 idle ticks", fast_stable, 0);

    // R4 tap change mid-countdown continues the countdown
    do_reset();
    write_sel(3'd1, 1'b0);
    ticks(2);
    write_sel(3'd7, 1'b0);
    check("R2 tap 7", tap_en, 8'h80);
    ticks(SETTLE - 3);
    check("R4 mid-count unstable", fast_stable, 0);
    ticks(1);
    check("R4 countdown not restarted", fast_stable, 1);

    // R5 write 000 mid-countdown cancels
    do_reset();
    write_sel(3'd5, 1'b0);
    ticks(2);
    write_sel(3'd0, 1'b0);
    ticks(SETTLE + 3);
    check("R5 cancelled", fast_stable, 0);
    check("R5 slow tap", tap_en, 8'h01);

    // R8 start-up count for each crystal mode
    for (int m = 1; m < 4; m++) begin
      do_reset();
      write_sel(3'd4, 1'b0);
      mode_req = 2'(m); step();
      check("R8 not ready at entry", clk_ready, 0);
      check("R2 internal tap while waiting", tap_en, 8'h10);
      edges(OST - 1);
      check("R8 not ready one short", clk_ready, 0);
      check("R8 ext not selected yet", ext_sel, 0);
      edges(1);
      check("R8 ready", clk_ready, 1);
      check("R8 ext selected", ext_sel, 1);
      check("R2 taps off", tap_en, 0);
    end

    // R9 restart on mode change, edge in change cycle ignored
    do_reset();
    mode_req = 2'd1; step();
    edges(OST - 2);
    mode_req = 2'd2; xosc_edge = 1'b1; step(); xosc_edge = 1'b0;
    check("R9 dropped on change", clk_ready, 0);
    edges(OST - 1);
    check("R9 count restarted", clk_ready, 0);
    edges(1);
    check("R9 ready after full recount", clk_ready, 1);
    mode_req = 2'd3; step();
    check("R9 ready drops on crystal-to-crystal change", clk_ready, 0);

    // R9 edges in internal mode not counted; R7 ready internally
    do_reset();
    edges(OST + 2);
    check("R7 internal ready", clk_ready, 1);
    mode_req = 2'd2; step();
    edges(OST - 1);
    check("R9 internal edges ignored", clk_ready, 0);
    mode_req = 2'd0; step();
    check("R7 ready back in internal", clk_ready, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule